// File: doc/BRIEF.md
# DMA Channel Control and Status Register Bank

This block is the software-facing register file of a single-channel DMA engine. It sits on a simple word-addressed write/read port with a 3-bit word index. Software uses it to program the source start address, the destination start address, the byte count and a control word. It reads back completion status through the same port. The control fields and programmed values go straight to the transfer engine as configuration outputs.

The engine reports back on four inputs: its in-progress state, a read-side end-of-packet event, a write-side end-of-packet event, and each new value of the remaining byte count. From these the block keeps sticky completion flags, one per cause, plus a common done flag. It raises a single interrupt line when done is set and interrupts are enabled. Any write to the status word clears the sticky flags, whatever data is written. Reads are combinational and have no side effects.

Top module: `dma_csr_bank`

## Requirements
- R1: Word offsets are decoded as follows: 0 = status, 1 = source address (ADDR_W bits), 2 = destination address (ADDR_W bits), 3 = byte count (LEN_W bits), 6 = control (10 bits). Every register reads back zero-extended to 32 bits, and write data above a register's width is dropped.
- R2: Offsets 4, 5 and 7 read as zero, and writes to them leave every register unchanged.
- R3: After reset, control reads 0x004 (word size selected), both addresses and the byte count read 0, the status flags read 0, and irq is low.
- R4: Status bit positions are: done = bit 0, busy = bit 1, read-EOP = bit 2, write-EOP = bit 3, count-exhausted = bit 4. Bits 31..5 read zero. Busy always mirrors `eng_busy`, and writes cannot change it.
- R5: Any write to offset 0 clears the done, read-EOP, write-EOP and count-exhausted flags, regardless of the data. An event arriving in the same cycle as that write is kept.
- R6: A read-side EOP event sets the read-EOP flag and done only when control bit 5 is 1. A write-side EOP event sets the write-EOP flag and done only when control bit 6 is 1. Otherwise the event has no effect.
- R7: An engine count update loads the byte count register. If the loaded value is 0 and control bit 7 is 1, the count-exhausted flag and done are set. If the value is 0 and bit 7 is 0, no flag changes. A software write to offset 3 in the same cycle wins over the engine update.
- R8: irq equals done AND control bit 4. When bit 4 is 0, irq stays low.
- R9: Control bits drive the engine outputs as follows: bits 2..0 size (bit 0 byte, bit 1 half-word, bit 2 word), bit 3 go, bit 5 read-EOP enable, bit 6 write-EOP enable, bit 7 count-end enable, bit 8 fixed source address, bit 9 fixed destination address.
- R10: Reading any offset changes no register or flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_addr | input | 3 | Word offset |
| csr_wr | input | 1 | Write strobe |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data for csr_addr (combinational) |
| eng_busy | input | 1 | Engine transfer in progress |
| eng_rd_eop | input | 1 | Read-side end-of-packet event (one cycle) |
| eng_wr_eop | input | 1 | Write-side end-of-packet event (one cycle) |
| eng_len_vld | input | 1 | Engine byte count update strobe |
| eng_len_val | input | LEN_W | Updated byte count |
| cfg_rd_addr | output | ADDR_W | Source start address |
| cfg_wr_addr | output | ADDR_W | Destination start address |
| cfg_len | output | LEN_W | Current byte count |
| cfg_size | output | 3 | Transfer size select (byte, half-word, word) |
| cfg_go | output | 1 | Engine enable |
| cfg_rd_eop_en | output | 1 | Read-side EOP ends transfer |
| cfg_wr_eop_en | output | 1 | Write-side EOP ends transfer |
| cfg_len_en | output | 1 | Count reaching zero ends transfer |
| cfg_rd_fixed | output | 1 | Hold source address constant |
| cfg_wr_fixed | output | 1 | Hold destination address constant |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the bank with ADDR_W = 12 and LEN_W = 8. Both are narrower than the 32-bit data port, so writing all-ones patterns shows that high bits are truncated and that the readback is zero-extended. The 8-bit count also makes a write of 0x1FF read back as 0xFF. The default control reset value is kept, so the word-size reset state is visible at offset 6. Same-cycle collisions are driven on purpose: a status clear together with an event, and a software count write together with an engine count update.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;
   localparam int unsigned CSR_DW = 32;
   localparam int unsigned CTRL_W = 10;
   localparam int unsigned STS_W  = 5;

   localparam logic [2:0] OFS_STATUS = 3'd0;
   localparam logic [2:0] OFS_RDADDR = 3'd1;
   localparam logic [2:0] OFS_WRADDR = 3'd2;
   localparam logic [2:0] OFS_COUNT  = 3'd3;
   localparam logic [2:0] OFS_CTRL   = 3'd6;

   // Packed so that bit positions equal the control word layout (size at 2..0).
   typedef struct packed {
      logic       wr_fixed;  // 9
      logic       rd_fixed;  // 8
      logic       len_en;    // 7
      logic       wr_eop_en; // 6
      logic       rd_eop_en; // 5
      logic       irq_en;    // 4
      logic       go;        // 3
      logic [2:0] size;      // 2..0
   } ctrl_t;
endpackage

// File: rtl/dma_csr_regs.sv
module dma_csr_regs
   import dma_csr_pkg::*;
#(
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned LEN_W    = 8,
   parameter logic [31:0] RD_RST   = '0,
   parameter logic [31:0] WR_RST   = '0,
   parameter logic [31:0] LEN_RST  = '0,
   parameter logic [31:0] CTRL_RST = 32'h0000_0004
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        addr,
   input  logic [31:0]       wdata,
   input  logic              len_vld,
   input  logic [LEN_W-1:0]  len_val,
   output logic [ADDR_W-1:0] rd_base,
   output logic [ADDR_W-1:0] wr_base,
   output logic [LEN_W-1:0]  len_q,
   output ctrl_t             ctrl_q,
   output logic              len_hit
);
   logic wr_rd, wr_wr, wr_len, wr_ctrl, eng_take;

   assign wr_rd    = wr_en && (addr == OFS_RDADDR);
   assign wr_wr    = wr_en && (addr == OFS_WRADDR);
   assign wr_len   = wr_en && (addr == OFS_COUNT);
   assign wr_ctrl  = wr_en && (addr == OFS_CTRL);
   // Software write owns the count register in a collision.
   assign eng_take = len_vld && !wr_len;
   assign len_hit  = eng_take && (len_val == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_base <= RD_RST[ADDR_W-1:0];
         wr_base <= WR_RST[ADDR_W-1:0];
         len_q   <= LEN_RST[LEN_W-1:0];
         ctrl_q  <= ctrl_t'(CTRL_RST[CTRL_W-1:0]);
      end else begin
         if (wr_rd)    rd_base <= wdata[ADDR_W-1:0];
         if (wr_wr)    wr_base <= wdata[ADDR_W-1:0];
         if (wr_len)        len_q <= wdata[LEN_W-1:0];
         else if (eng_take) len_q <= len_val;
         if (wr_ctrl)  ctrl_q  <= ctrl_t'(wdata[CTRL_W-1:0]);
      end
   end
endmodule

// File: rtl/dma_csr_status.sv
module dma_csr_status
   import dma_csr_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             rd_eop,
   input  logic             wr_eop,
   input  logic             len_hit,
   input  logic             busy,
   input  ctrl_t            ctrl,
   output logic [STS_W-1:0] sts,
   output logic             done,
   output logic             irq
);
   logic f_reop, f_weop, f_len;
   logic e_reop, e_weop, e_len;

   assign e_reop = rd_eop  && ctrl.rd_eop_en;
   assign e_weop = wr_eop  && ctrl.wr_eop_en;
   assign e_len  = len_hit && ctrl.len_en;

   // Clear first, then OR in this cycle's events so none is lost.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         f_reop <= 1'b0;
         f_weop <= 1'b0;
         f_len  <= 1'b0;
         done   <= 1'b0;
      end else begin
         f_reop <= (f_reop && !clr) || e_reop;
         f_weop <= (f_weop && !clr) || e_weop;
         f_len  <= (f_len  && !clr) || e_len;
         done   <= (done   && !clr) || e_reop || e_weop || e_len;
      end
   end

   assign sts = {f_len, f_weop, f_reop, busy, done};
   assign irq = done && ctrl.irq_en;
endmodule

// File: rtl/dma_csr_rdmux.sv
module dma_csr_rdmux
   import dma_csr_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned LEN_W  = 8
) (
   input  logic [2:0]        addr,
   input  logic [STS_W-1:0]  sts,
   input  logic [ADDR_W-1:0] rd_base,
   input  logic [ADDR_W-1:0] wr_base,
   input  logic [LEN_W-1:0]  len_q,
   input  ctrl_t             ctrl,
   output logic [31:0]       rdata
);
   logic [31:0] rd_ext, wr_ext, len_ext;

   if (ADDR_W < CSR_DW) begin : g_addr_pad
      assign rd_ext = {{(CSR_DW-ADDR_W){1'b0}}, rd_base};
      assign wr_ext = {{(CSR_DW-ADDR_W){1'b0}}, wr_base};
   end else begin : g_addr_full
      assign rd_ext = rd_base;
      assign wr_ext = wr_base;
   end

   if (LEN_W < CSR_DW) begin : g_len_pad
      assign len_ext = {{(CSR_DW-LEN_W){1'b0}}, len_q};
   end else begin : g_len_full
      assign len_ext = len_q;
   end

   always_comb begin
      unique case (addr)
         OFS_STATUS: rdata = {{(CSR_DW-STS_W){1'b0}}, sts};
         OFS_RDADDR: rdata = rd_ext;
         OFS_WRADDR: rdata = wr_ext;
         OFS_COUNT:  rdata = len_ext;
         OFS_CTRL:   rdata = {{(CSR_DW-CTRL_W){1'b0}}, ctrl};
         default:    rdata = '0;
      endcase
   end
endmodule

// File: rtl/dma_csr_bank.sv
module dma_csr_bank
   import dma_csr_pkg::*;
#(
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned LEN_W    = 8,
   parameter logic [31:0] RD_RST   = '0,
   parameter logic [31:0] WR_RST   = '0,
   parameter logic [31:0] LEN_RST  = '0,
   parameter logic [31:0] CTRL_RST = 32'h0000_0004
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        csr_addr,
   input  logic              csr_wr,
   input  logic [31:0]       csr_wdata,
   output logic [31:0]       csr_rdata,
   input  logic              eng_busy,
   input  logic              eng_rd_eop,
   input  logic              eng_wr_eop,
   input  logic              eng_len_vld,
   input  logic [LEN_W-1:0]  eng_len_val,
   output logic [ADDR_W-1:0] cfg_rd_addr,
   output logic [ADDR_W-1:0] cfg_wr_addr,
   output logic [LEN_W-1:0]  cfg_len,
   output logic [2:0]        cfg_size,
   output logic              cfg_go,
   output logic              cfg_rd_eop_en,
   output logic              cfg_wr_eop_en,
   output logic              cfg_len_en,
   output logic              cfg_rd_fixed,
   output logic              cfg_wr_fixed,
   output logic              irq
);
   if (LEN_W < 1 || LEN_W > 32) begin : g_bad_len
      $error("dma_csr_bank: LEN_W must be 1..32");
   end
   if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_addr
      $error("dma_csr_bank: ADDR_W must be 1..32");
   end
   if (CTRL_RST[31:CTRL_W] != '0) begin : g_bad_ctrl
      $error("dma_csr_bank: CTRL_RST has bits above the control field");
   end

   ctrl_t            ctrl_q;
   logic [STS_W-1:0] sts;
   logic             len_hit, sts_done, sts_clr;

   assign sts_clr = csr_wr && (csr_addr == OFS_STATUS);

   dma_csr_regs #(
      .ADDR_W(ADDR_W), .LEN_W(LEN_W), .RD_RST(RD_RST),
      .WR_RST(WR_RST), .LEN_RST(LEN_RST), .CTRL_RST(CTRL_RST)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(csr_wr), .addr(csr_addr),
      .wdata(csr_wdata), .len_vld(eng_len_vld), .len_val(eng_len_val),
      .rd_base(cfg_rd_addr), .wr_base(cfg_wr_addr), .len_q(cfg_len),
      .ctrl_q(ctrl_q), .len_hit(len_hit)
   );

   dma_csr_status u_status (
      .clk(clk), .rst_n(rst_n), .clr(sts_clr), .rd_eop(eng_rd_eop),
      .wr_eop(eng_wr_eop), .len_hit(len_hit), .busy(eng_busy),
      .ctrl(ctrl_q), .sts(sts), .done(sts_done), .irq(irq)
   );

   dma_csr_rdmux #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_rdmux (
      .addr(csr_addr), .sts(sts), .rd_base(cfg_rd_addr),
      .wr_base(cfg_wr_addr), .len_q(cfg_len), .ctrl(ctrl_q),
      .rdata(csr_rdata)
   );

   assign cfg_size      = ctrl_q.size;
   assign cfg_go        = ctrl_q.go;
   assign cfg_rd_eop_en = ctrl_q.rd_eop_en;
   assign cfg_wr_eop_en = ctrl_q.wr_eop_en;
   assign cfg_len_en    = ctrl_q.len_en;
   assign cfg_rd_fixed  = ctrl_q.rd_fixed;
   assign cfg_wr_fixed  = ctrl_q.wr_fixed;
endmodule

// File: rtl/dma_csr_bank_chk.sv
module dma_csr_bank_chk #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned LEN_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [2:0]        csr_addr,
   input logic              csr_wr,
   input logic [31:0]       csr_rdata,
   input logic              eng_busy,
   input logic              eng_rd_eop,
   input logic              eng_wr_eop,
   input logic              eng_len_vld,
   input logic [ADDR_W-1:0] cfg_rd_addr,
   input logic [ADDR_W-1:0] cfg_wr_addr,
   input logic [LEN_W-1:0]  cfg_len,
   input logic              cfg_rd_eop_en,
   input logic              irq_en,
   input logic              done,
   input logic              irq
);
   AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> irq_en); // R8
   AST_STATUS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_wr && csr_addr == 3'd0 && !eng_rd_eop && !eng_wr_eop && !eng_len_vld)
      |=> !done); // R5
   AST_REOP_SETS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_rd_eop && cfg_rd_eop_en) |=> done); // R6
   AST_RSVD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_wr && (csr_addr == 3'd4 || csr_addr == 3'd5 || csr_addr == 3'd7) && !eng_len_vld)
      |=> ($stable(cfg_rd_addr) && $stable(cfg_wr_addr) && $stable(cfg_len))); // R2
   AST_BUSY_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_addr == 3'd0) |-> (csr_rdata[1] == eng_busy)); // R4
   AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_addr == 3'd0 || csr_addr == 3'd6) |-> (csr_rdata[31:10] == '0)); // R1
endmodule

bind dma_csr_bank dma_csr_bank_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_wr(csr_wr),
   .csr_rdata(csr_rdata), .eng_busy(eng_busy), .eng_rd_eop(eng_rd_eop),
   .eng_wr_eop(eng_wr_eop), .eng_len_vld(eng_len_vld),
   .cfg_rd_addr(cfg_rd_addr), .cfg_wr_addr(cfg_wr_addr), .cfg_len(cfg_len),
   .cfg_rd_eop_en(cfg_rd_eop_en), .irq_en(ctrl_q.irq_en), .done(sts_done),
   .irq(irq)
);

// File: tb/dma_csr_bank_tb_top.sv
module dma_csr_bank_tb_top;
   localparam int unsigned ADDR_W = 12;
   localparam int unsigned LEN_W  = 8;
   localparam int NVEC = 8;

   // {offset[66:64], write data[63:32], expected readback[31:0]}
   localparam logic [66:0] VECS [0:NVEC-1] = '{
      {3'd1, 32'hFFFF_F123, 32'h0000_0123},
      {3'd2, 32'h0000_0ABC, 32'h0000_0ABC},
      {3'd3, 32'h0000_01FF, 32'h0000_00FF},
      {3'd6, 32'hFFFF_FFFF, 32'h0000_03FF},
      {3'd4, 32'hFFFF_FFFF, 32'h0000_0000},
      {3'd5, 32'hFFFF_FFFF, 32'h0000_0000},
      {3'd7, 32'hFFFF_FFFF, 32'h0000_0000},
      {3'd6, 32'h0000_0122, 32'h0000_0122}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [2:0]        csr_addr = '0;
   logic              csr_wr = 1'b0;
   logic [31:0]       csr_wdata = '0;
   logic [31:0]       csr_rdata;
   logic              eng_busy = 1'b0;
   logic              eng_rd_eop = 1'b0;
   logic              eng_wr_eop = 1'b0;
   logic              eng_len_vld = 1'b0;
   logic [LEN_W-1:0]  eng_len_val = '0;
   logic [ADDR_W-1:0] cfg_rd_addr, cfg_wr_addr;
   logic [LEN_W-1:0]  cfg_len;
   logic [2:0]        cfg_size;
   logic cfg_go, cfg_rd_eop_en, cfg_wr_eop_en, cfg_len_en, cfg_rd_fixed, cfg_wr_fixed, irq;

   int n_chk = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   dma_csr_bank #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_wr(csr_wr),
      .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .eng_busy(eng_busy),
      .eng_rd_eop(eng_rd_eop), .eng_wr_eop(eng_wr_eop),
      .eng_len_vld(eng_len_vld), .eng_len_val(eng_len_val),
      .cfg_rd_addr(cfg_rd_addr), .cfg_wr_addr(cfg_wr_addr), .cfg_len(cfg_len),
      .cfg_size(cfg_size), .cfg_go(cfg_go), .cfg_rd_eop_en(cfg_rd_eop_en),
      .cfg_wr_eop_en(cfg_wr_eop_en), .cfg_len_en(cfg_len_en),
      .cfg_rd_fixed(cfg_rd_fixed), .cfg_wr_fixed(cfg_wr_fixed), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   // One clock of stimulus, applied at a falling edge, released at the next.
   task automatic step(input logic [2:0] a, input logic w, input logic [31:0] d,
                       input logic re, input logic we, input logic lv,
                       input logic [LEN_W-1:0] lval);
      @(negedge clk);
      csr_addr = a; csr_wr = w; csr_wdata = d;
      eng_rd_eop = re; eng_wr_eop = we; eng_len_vld = lv; eng_len_val = lval;
      @(negedge clk);
      csr_wr = 1'b0; eng_rd_eop = 1'b0; eng_wr_eop = 1'b0; eng_len_vld = 1'b0;
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      step(a, 1'b1, d, 1'b0, 1'b0, 1'b0, '0);
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] v);
      csr_addr = a;
      #1 v = csr_rdata;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R3 reset state
      rd(3'd0, v); chk("R3 status", v, 32'h0);
      rd(3'd6, v); chk("R3 control", v, 32'h4);
      rd(3'd1, v); chk("R3 src addr", v, 32'h0);
      rd(3'd3, v); chk("R3 count", v, 32'h0);
      chk("R3 irq", {31'b0, irq}, 32'h0);

      // R1 / R2 vector walk
      for (int i = 0; i < NVEC; i++) begin
         logic [2:0] a;
         a = VECS[i][66:64];
         wr(a, VECS[i][63:32]);
         rd(a, v);
         chk((a == 3'd4 || a == 3'd5 || a == 3'd7) ? "R2 reserved" : "R1 readback",
             v, VECS[i][31:0]);
      end
      rd(3'd1, v); chk("R2 src kept", v, 32'h123);
      rd(3'd3, v); chk("R2 count kept", v, 32'hFF);
      // R9 control 0x122: half-word, read-EOP enable, fixed source
      chk("R9 outputs",
          {22'b0, cfg_wr_fixed, cfg_rd_fixed, cfg_len_en, cfg_wr_eop_en,
           cfg_rd_eop_en, 1'b0, cfg_go, cfg_size}, 32'h122);

      // R4 busy mirror, not writable
      eng_busy = 1'b1;
      rd(3'd0, v); chk("R4 busy set", v, 32'h2);
      wr(3'd0, 32'hFFFF_FFFF);
      eng_busy = 1'b0;
      rd(3'd0, v); chk("R4 busy clear", v, 32'h0);

      // R6 / R8 read EOP with interrupt enable
      wr(3'd6, 32'h034);
      step(3'd0, 1'b0, '0, 1'b1, 1'b0, 1'b0, '0);
      rd(3'd0, v); chk("R6 reop", v, 32'h5);
      chk("R8 irq on", {31'b0, irq}, 32'h1);
      rd(3'd0, v); chk("R10 read no side effect", v, 32'h5);
      wr(3'd0, 32'h0);
      rd(3'd0, v); chk("R5 clear", v, 32'h0);
      chk("R5 irq off", {31'b0, irq}, 32'h0);

      // R6 read EOP disabled
      wr(3'd6, 32'h004);
      step(3'd0, 1'b0, '0, 1'b1, 1'b0, 1'b0, '0);
      rd(3'd0, v); chk("R6 reop ignored", v, 32'h0);

      // R6 / R8 write EOP, interrupts gated
      wr(3'd6, 32'h044);
      step(3'd0, 1'b0, '0, 1'b0, 1'b1, 1'b0, '0);
      rd(3'd0, v); chk("R6 weop", v, 32'h9);
      chk("R8 irq gated", {31'b0, irq}, 32'h0);
      wr(3'd6, 32'h054);
      chk("R8 irq after enable", {31'b0, irq}, 32'h1);

      // R5 clear and new event in the same cycle
      step(3'd0, 1'b1, 32'h1F, 1'b0, 1'b1, 1'b0, '0);
      rd(3'd0, v); chk("R5 event survives clear", v, 32'h9);
      wr(3'd0, 32'h0);

      // R7 count exhaustion
      wr(3'd6, 32'h084);
      wr(3'd3, 32'h4);
      step(3'd0, 1'b0, '0, 1'b0, 1'b0, 1'b1, 8'd2);
      rd(3'd3, v); chk("R7 count update", v, 32'h2);
      rd(3'd0, v); chk("R7 nonzero no flag", v, 32'h0);
      step(3'd0, 1'b0, '0, 1'b0, 1'b0, 1'b1, 8'd0);
      rd(3'd0, v); chk("R7 count end", v, 32'h11);
      wr(3'd0, 32'h0);
      wr(3'd6, 32'h004);
      step(3'd0, 1'b0, '0, 1'b0, 1'b0, 1'b1, 8'd0);
      rd(3'd0, v); chk("R7 end disabled", v, 32'h0);
      step(3'd3, 1'b1, 32'h55, 1'b0, 1'b0, 1'b1, 8'h11);
      rd(3'd3, v); chk("R7 software wins", v, 32'h55);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule